// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block drives the command pins of a synchronous DRAM from the moment power and clock are declared good until the memory may take ordinary traffic. Until the stability input has been seen high, it holds the chip deselected. Then it enters a quiet period of NOP cycles whose length is derived from the clock frequency and a microsecond figure. After that it closes every bank with an all-bank precharge and runs two auto-refresh cycles. Finally it writes the caller's mode word into the mode register. After each of these commands it waits a programmable number of NOP cycles.

When the last wait has elapsed, a level `ready` output goes high and stays high. A companion output pulses for the single cycle in which `ready` rises. A synchronous reset throws away all progress and restarts from the deselected state. The mode word is taken from an input port, so the same block serves any burst length, burst type or CAS latency choice.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after its release, the pins show a deselect (`cs_n`=1). `addr` and `ba` are zero and `ready` and `ready_pulse` are low.
- R2: Once `pwr_stable` has been sampled high, exactly `CLK_MHZ*STARTUP_US` consecutive NOP cycles are issued (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1), and the first of them follows the deselect cycles directly.
- R3: The command right after the quiet period is a precharge (0,0,1,0) with `addr[10]`=1, which selects all banks.
- R4: After the precharge exactly `T_RP` NOP cycles pass, then an auto refresh (0,0,0,1) is issued. Exactly `T_RC` NOP cycles follow it.
- R5: A second auto refresh comes next, followed by exactly `T_RC` NOP cycles. No other refresh is ever issued during start-up or afterwards.
- R6: The next command is a mode load (0,0,0,0) with `addr[9:0]`=`mode_word`, `addr[12:10]`=0 and `ba`=0.
- R7: Exactly `T_MRD` NOP cycles after the mode load, `ready` rises, and `ready_pulse` is high in that cycle only.
- R8: Once `ready` is high it stays high, the pins show NOP with `addr`=0, and changes on `mode_word` have no effect on them.
- R9: Asserting `rst` at any point in the sequence drops `ready` and returns the pins to deselect. After release the complete sequence runs again from the quiet period.
- R10: While `pwr_stable` stays low after reset, the pins remain at deselect indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pwr_stable | input | 1 | Supply and clock are stable |
| mode_word | input | 10 | Mode register value (burst length 2:0, burst type 3, CAS latency 6:4, operating mode 8:7, write burst 9) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | Address bus |
| ba | output | 2 | Bank address |
| ready | output | 1 | Start-up complete, sticky |
| ready_pulse | output | 1 | One-cycle strobe when `ready` rises |

## Verification
The bench counts the NOP cycles between every pair of commands. A wait counter that is off by one, and so loads its full count instead of count minus one, shows up as one NOP too many in the quiet period or in one of the gaps. A design that skips the second refresh, or adds a third, fails the command-order checks. A design that passes the two reserved mode bits or bit 12 through, or leaves `addr[10]` low on the precharge, is caught by the address checks. A reset in the middle of the sequence must clear `ready` and replay the full sequence, and a `ready_pulse` that lasts longer than one cycle is flagged by the check made on the cycle after `ready` rises.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Pin pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } cmd_t;

    typedef enum logic [3:0] {
        PH_IDLE, PH_QUIET, PH_PRE, PH_WRP, PH_REF1, PH_WRC1,
        PH_REF2, PH_WRC2, PH_MRS, PH_WMRD, PH_DONE
    } phase_t;

    typedef struct packed {
        cmd_t        cmd;
        logic [12:0] addr;
        logic [1:0]  ba;
    } pin_bundle_t;

    localparam int ALL_BANK_BIT = 10;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Reserved positions and bit 12 are forced low
    function automatic logic [12:0] mode_to_addr(input logic [9:0] mw);
        return {3'b000, mw};
    endfunction

    function automatic logic [12:0] precharge_addr();
        logic [12:0] a;
        a = '0;
        a[ALL_BANK_BIT] = 1'b1;
        return a;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

    a_r4_timer_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    a_r4_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/init_phase_fsm.sv
module init_phase_fsm
    import sdram_init_pkg::*;
#(
    parameter int CW          = 8,
    parameter int STARTUP_CYC = 100,
    parameter int T_RP        = 3,
    parameter int T_RC        = 8,
    parameter int T_MRD       = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_ok,
    input  logic          tmr_expired,
    output phase_t        phase,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);
    localparam logic [CW-1:0] V_START = CW'(STARTUP_CYC - 1);
    localparam logic [CW-1:0] V_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] V_RC    = CW'(T_RC - 1);
    localparam logic [CW-1:0] V_MRD   = CW'(T_MRD - 1);

    phase_t nxt;

    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase)
            PH_IDLE:  if (pwr_ok) begin nxt = PH_QUIET; tmr_load = 1'b1; tmr_val = V_START; end
            PH_QUIET: if (tmr_expired) nxt = PH_PRE;
            PH_PRE:   begin nxt = PH_WRP;  tmr_load = 1'b1; tmr_val = V_RP;  end
            PH_WRP:   if (tmr_expired) nxt = PH_REF1;
            PH_REF1:  begin nxt = PH_WRC1; tmr_load = 1'b1; tmr_val = V_RC;  end
            PH_WRC1:  if (tmr_expired) nxt = PH_REF2;
            PH_REF2:  begin nxt = PH_WRC2; tmr_load = 1'b1; tmr_val = V_RC;  end
            PH_WRC2:  if (tmr_expired) nxt = PH_MRS;
            PH_MRS:   begin nxt = PH_WMRD; tmr_load = 1'b1; tmr_val = V_MRD; end
            PH_WMRD:  if (tmr_expired) nxt = PH_DONE;
            PH_DONE:  nxt = PH_DONE;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !pwr_ok) |=> (phase == PH_IDLE));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase == PH_DONE));

    a_r5_ref_pair: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REF2) |-> ($past(phase) == PH_WRC1));

endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
    import sdram_init_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_t      phase,
    input  logic [9:0]  mode_word,
    output pin_bundle_t pins,
    output logic        ready,
    output logic        ready_pulse
);
    pin_bundle_t nxt;

    always_comb begin
        nxt.cmd  = CMD_NOP;
        nxt.addr = '0;
        nxt.ba   = '0;
        unique case (phase)
            PH_IDLE: nxt.cmd = CMD_INH;
            PH_PRE:  begin nxt.cmd = CMD_PRE; nxt.addr = precharge_addr(); end
            PH_REF1, PH_REF2: nxt.cmd = CMD_REF;
            PH_MRS:  begin nxt.cmd = CMD_LMR; nxt.addr = mode_to_addr(mode_word); end
            default: nxt.cmd = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins.cmd    <= CMD_INH;
            pins.addr   <= '0;
            pins.ba     <= '0;
            ready       <= 1'b0;
            ready_pulse <= 1'b0;
        end else begin
            pins        <= nxt;
            ready       <= (phase == PH_DONE);
            ready_pulse <= (phase == PH_DONE) && !ready;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int STARTUP_US = 100,
    parameter int T_RP       = 3,
    parameter int T_RC       = 8,
    parameter int T_MRD      = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_stable,
    input  logic [9:0]  mode_word,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [12:0] addr,
    output logic [1:0]  ba,
    output logic        ready,
    output logic        ready_pulse
);
    localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;
    localparam int MAXW        = max4(STARTUP_CYC, T_RP, T_RC, T_MRD);
    localparam int CW          = $clog2(MAXW + 1);

    phase_t        phase;
    logic          tmr_load, tmr_expired;
    logic [CW-1:0] tmr_val;
    pin_bundle_t   pins;

    init_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    init_phase_fsm #(
        .CW(CW), .STARTUP_CYC(STARTUP_CYC), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
    ) u_fsm (
        .clk(clk), .rst(rst), .pwr_ok(pwr_stable), .tmr_expired(tmr_expired),
        .phase(phase), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    init_cmd_encoder u_enc (
        .clk(clk), .rst(rst), .phase(phase), .mode_word(mode_word),
        .pins(pins), .ready(ready), .ready_pulse(ready_pulse)
    );

    assign {cs_n, ras_n, cas_n, we_n} = pins.cmd;
    assign addr = pins.addr;
    assign ba   = pins.ba;

    initial begin
        a_r2_params: assert (STARTUP_CYC >= 1 && T_RP >= 1 && T_RC >= 1 && T_MRD >= 1);
    end

    a_r3_pre_all: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[10]);

    a_r6_lmr_addr: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |-> (addr[12:10] == 3'b000 && ba == 2'b00));

    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r7_pulse_edge: assert property (@(posedge clk) disable iff (rst)
        ready_pulse |-> $rose(ready));

    a_r8_quiet_after: assert property (@(posedge clk) disable iff (rst)
        ready |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0));

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
    localparam int CLK_MHZ = 1, STARTUP_US = 20, T_RP = 3, T_RC = 5, T_MRD = 2;
    localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;

    logic clk = 1'b0, rst = 1'b1, pwr_stable = 1'b0;
    logic [9:0] mode_word = '0;
    logic cs_n, ras_n, cas_n, we_n, ready, ready_pulse;
    logic [12:0] addr;
    logic [1:0] ba;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US),
                     .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) dut (
        .clk(clk), .rst(rst), .pwr_stable(pwr_stable), .mode_word(mode_word),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .ready(ready), .ready_pulse(ready_pulse)
    );

    function automatic logic [3:0] pinsv();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Count NOP cycles (ready low) until something else shows up
    task automatic count_nops(output int n);
        n = 0;
        while (pinsv() == 4'b0111 && !ready && n < STARTUP_CYC + 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; pwr_stable = 1'b0;
        repeat (3) @(negedge clk);
        chk(pinsv() == 4'b1111 && addr == 0 && ba == 0 && !ready && !ready_pulse,
            "R1 in reset", {pinsv(), addr, ba, ready}, {4'b1111, 13'h0, 2'b0, 1'b0});
        rst = 1'b0;
        @(negedge clk);
        chk(pinsv() == 4'b1111 && !ready, "R1 after release", pinsv(), 4'b1111);
    endtask

    task automatic t_hold_unstable();
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pinsv() != 4'b1111 || ready) bad++;
        end
        chk(bad == 0, "R10 deselect held", bad, 0);
    endtask

    task automatic t_full(input logic [9:0] mw, input string tag);
        int n, guard, bad;
        mode_word = mw;
        pwr_stable = 1'b1;
        @(negedge clk);
        guard = 0;
        while (pinsv() == 4'b1111 && guard < 4) begin guard++; @(negedge clk); end
        chk(pinsv() == 4'b0111, {"R2 first after deselect ", tag}, pinsv(), 4'b0111);
        count_nops(n);
        chk(n == STARTUP_CYC, {"R2 quiet length ", tag}, n, STARTUP_CYC);
        chk(pinsv() == 4'b0010 && addr[10], {"R3 precharge all ", tag}, {pinsv(), addr}, {4'b0010, 13'h0400});
        @(negedge clk);
        count_nops(n);
        chk(n == T_RP, {"R4 tRP gap ", tag}, n, T_RP);
        chk(pinsv() == 4'b0001, {"R4 first refresh ", tag}, pinsv(), 4'b0001);
        @(negedge clk);
        count_nops(n);
        chk(n == T_RC, {"R4 tRC gap 1 ", tag}, n, T_RC);
        chk(pinsv() == 4'b0001, {"R5 second refresh ", tag}, pinsv(), 4'b0001);
        @(negedge clk);
        count_nops(n);
        chk(n == T_RC, {"R5 tRC gap 2 ", tag}, n, T_RC);
        chk(pinsv() == 4'b0000, {"R6 mode load cmd ", tag}, pinsv(), 4'b0000);
        chk(addr == {3'b000, mw} && ba == 2'b00, {"R6 mode load addr ", tag},
            {ba, addr}, {2'b00, 3'b000, mw});
        @(negedge clk);
        count_nops(n);
        chk(n == T_MRD && ready && ready_pulse, {"R7 ready timing ", tag},
            {n[15:0], 6'b0, ready, ready_pulse}, {T_MRD[15:0], 8'b00000011});
        @(negedge clk);
        chk(ready && !ready_pulse, {"R7 pulse single ", tag}, {ready, ready_pulse}, 2'b10);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            mode_word = mode_word ^ 10'h3FF;
            @(negedge clk);
            if (!ready || ready_pulse || pinsv() != 4'b0111 || addr != 0 || ba != 0) bad++;
        end
        chk(bad == 0, {"R8 R5 idle after ready ", tag}, bad, 0);
    endtask

    task automatic t_midreset();
        int guard = 0;
        pwr_stable = 1'b1;
        while (pinsv() != 4'b0001 && guard < STARTUP_CYC + 20) begin guard++; @(negedge clk); end
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(pinsv() == 4'b1111 && !ready, "R9 reset mid sequence", {pinsv(), ready}, {4'b1111, 1'b0});
        rst = 1'b0;
        t_full(10'h0A2, "R9 replay");
    endtask

    initial begin
        t_reset();
        t_hold_unstable();
        t_full(10'h233, "pattern A");
        t_midreset();
        t_reset();
        t_full(10'h3FF, "all ones");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule